// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block owns the 8-bit stack pointer of a small byte-wide processor and runs the multi-cycle memory sequences that use the stack. These sequences are single-byte push and pull, subroutine call and return, and entry into and return from an interrupt. The core hands it one request together with its current program counter and status byte. The sequencer then drives one memory access per cycle on a byte-wide bus. When the sequence completes it presents the resulting program counter, status byte or pulled byte, and raises a one-cycle completion pulse.

The stack sits in one fixed 256-byte page (page 0x01). The pointer names the next free byte. Writes store at the pointer and then move it down. Reads move the pointer up and then fetch. The pointer wraps silently at both ends of the page. Three sources enter an interrupt. A software break and a maskable hardware request share one vector, and only the break flag in the stacked status tells them apart. The non-maskable request has its own vector and always wins.

Top module: `ssq_stack_seq`

## Requirements
- R1: Every stack access (all writes and all non-vector reads) uses address 0x0100 plus the stack pointer, so the high address byte is always 0x01.
- R2: After reset the sequencer is idle with `busy`, `done`, `mem_we` and `mem_re` low, and the pointer is 0xFF, so the first push writes 0x01FF.
- R3: A push takes one write cycle that stores `push_data` at the pointer, then decrements the pointer.
- R4: A pull takes one read cycle that first increments the pointer, then reads that location and returns the byte on `pull_data`.
- R5: The pointer wraps with no detection: a pull at 0xFF reads 0x0100, and a push at 0x00 writes 0x0100 and leaves the pointer at 0xFF.
- R6: A break request writes PC high byte, PC low byte and then the status byte with bit 4 (break flag) set, at descending addresses. It then reads 0xFFFE (low) and 0xFFFF (high) into `pc_out`. `psw_out` is the input status with bit 2 (interrupt mask) set. The sequence takes 5 cycles.
- R7: A hardware interrupt request runs the same sequence as R6 but stacks the status with bit 4 clear. It is ignored entirely while `psw_in` bit 2 is set.
- R8: A non-maskable request runs the R7 sequence regardless of bit 2, reads its vector from 0xFFFA/0xFFFB, and wins over a hardware request arriving in the same cycle.
- R9: A return-from-interrupt request reads status, then PC low, then PC high from ascending stack addresses in 3 cycles. `psw_out` is the pulled status unchanged, and `pc_out` is the pulled address.
- R10: A call request writes PC high and then PC low in 2 cycles, and `pc_out` becomes `call_target`.
- R11: A return request reads PC low and then PC high in 2 cycles, and `pc_out` becomes that address.
- R12: `done` is high for exactly one cycle, the cycle after the final access. Requests are accepted only while idle: one arriving while busy has no effect. Simultaneous requests are served in the order non-maskable, hardware, break, return-from-interrupt, call, return, push, pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pull_req | input | 1 | Pull one byte |
| brk_req | input | 1 | Software break entry |
| irq_req | input | 1 | Maskable interrupt entry |
| nmi_req | input | 1 | Non-maskable interrupt entry |
| rti_req | input | 1 | Return from interrupt |
| call_req | input | 1 | Subroutine call |
| ret_req | input | 1 | Subroutine return |
| call_target | input | 16 | Destination of a call |
| pc_in | input | 16 | Current program counter (address stacked by entry and call) |
| psw_in | input | 8 | Current status byte |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one byte per cycle |
| mem_re | output | 1 | Read strobe |
| pc_out | output | 16 | Resulting program counter |
| psw_out | output | 8 | Resulting status byte |
| pull_data | output | 8 | Byte returned by the last pull |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A pointer that is off by one shows at once on `mem_addr`. The first stack access of the next sequence lands one byte off, and a pull then returns a neighbouring byte on `pull_data` one cycle later. A wrong state step shows as a write or read in the wrong cycle or order, or as a wrong cycle count before `done`. A lost break flag or mask bit surfaces in the stacked status byte during entry, and in `psw_out` at the end of the entry or of the following return.

// File: rtl/ssq_pkg.sv
// Package: shared state encoding and request indices for the stack sequencer.
// Assumes a byte-wide bus and one memory access per sequencer state.
package ssq_pkg;

    // Sequencer states: each non-idle state is exactly one memory access.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_PCH,
        ST_WR_PCL,
        ST_WR_PSW,
        ST_RD_VLO,
        ST_RD_VHI,
        ST_RD_PSW,
        ST_RD_PCL,
        ST_RD_PCH,
        ST_WR_BYTE,
        ST_RD_BYTE
    } ssq_state_e;

    // Request slots, lowest index has highest priority.
    localparam int RQ_NMI   = 0;
    localparam int RQ_IRQ   = 1;
    localparam int RQ_BRK   = 2;
    localparam int RQ_RTI   = 3;
    localparam int RQ_CALL  = 4;
    localparam int RQ_RET   = 5;
    localparam int RQ_PUSH  = 6;
    localparam int RQ_PULL  = 7;
    localparam int RQ_COUNT = 8;

    // True for states that store a byte on the stack.
    function automatic logic is_stack_write(input ssq_state_e s);
        return (s == ST_WR_PCH) || (s == ST_WR_PCL) ||
               (s == ST_WR_PSW) || (s == ST_WR_BYTE);
    endfunction

    // True for states that fetch a byte from the stack.
    function automatic logic is_stack_read(input ssq_state_e s);
        return (s == ST_RD_PSW) || (s == ST_RD_PCL) ||
               (s == ST_RD_PCH) || (s == ST_RD_BYTE);
    endfunction

    // True for states that fetch a vector byte.
    function automatic logic is_vector_read(input ssq_state_e s);
        return (s == ST_RD_VLO) || (s == ST_RD_VHI);
    endfunction

endpackage

// File: rtl/ssq_arbiter.sv
// Module: fixed-priority request selector.
// Produces a one-hot grant; index 0 wins. Purely combinational.
module ssq_arbiter #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    // One grant bit per slot, blocked by any higher-priority request.
    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    // Any request present.
    assign any = |req;

endmodule

// File: rtl/ssq_stack_ptr.sv
// Module: stack pointer register.
// Decrements after a stack write, increments for a stack read, wraps
// freely in both directions. Also offers pointer+1 as the read address.
module ssq_stack_ptr #(
    parameter int              SP_W   = 8,
    parameter logic [SP_W-1:0] SP_RST = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up
);

    // Pointer + 1, used as the address of a pull (increment then read).
    assign sp_up = sp + SP_W'(1);

    // Register update: write moves down, read moves up, modulo the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RST;
        end else if (dec) begin
            sp <= sp - SP_W'(1);
        end else if (inc) begin
            sp <= sp_up;
        end
    end

endmodule

// File: rtl/ssq_bus_mux.sv
// Module: memory bus driver for the stack sequencer.
// Maps the current state to address, write data and strobes. Assumes the
// program counter is exactly two data bytes wide.
module ssq_bus_mux
    import ssq_pkg::*;
#(
    parameter int                 AW         = 16,
    parameter int                 DW         = 8,
    parameter int                 B_BIT      = 4,
    parameter logic [AW-DW-1:0]   STACK_PAGE = 'h01,
    parameter logic [AW-1:0]      VEC_NMI    = 'hFFFA,
    parameter logic [AW-1:0]      VEC_IRQ    = 'hFFFE
) (
    input  ssq_state_e    state,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] sp_up,
    input  logic          vec_nmi,
    input  logic          brk_flag,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] psw,
    input  logic [DW-1:0] data,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          re
);

    logic [AW-1:0] vec_base;

    // Vector pair selected by the interrupt source.
    assign vec_base = vec_nmi ? VEC_NMI : VEC_IRQ;

    // Strobes follow the state class.
    assign we = is_stack_write(state);
    assign re = is_stack_read(state) || is_vector_read(state);

    // Address and write data for the access of this cycle.
    always_comb begin
        addr  = {STACK_PAGE, sp};
        wdata = '0;
        case (state)
            ST_WR_PCH:  wdata = pc[AW-1:DW];
            ST_WR_PCL:  wdata = pc[DW-1:0];
            ST_WR_PSW: begin
                wdata        = psw;
                wdata[B_BIT] = brk_flag;
            end
            ST_WR_BYTE: wdata = data;
            ST_RD_VLO:  addr  = vec_base;
            ST_RD_VHI:  addr  = vec_base + AW'(1);
            ST_RD_PSW,
            ST_RD_PCL,
            ST_RD_PCH,
            ST_RD_BYTE: addr  = {STACK_PAGE, sp_up};
            default:    addr  = {STACK_PAGE, sp};
        endcase
    end

endmodule

// File: rtl/ssq_stack_seq.sv
// Module: stack and interrupt entry sequencer (top).
// Accepts one request while idle, runs it as one memory access per cycle
// and pulses done the cycle after the last access. Assumes memory read
// data is valid in the same cycle as the address. Requests that arrive
// while busy are dropped.
module ssq_stack_seq
    import ssq_pkg::*;
#(
    parameter int               AW         = 16,
    parameter int               DW         = 8,
    parameter int               B_BIT      = 4,
    parameter int               I_BIT      = 2,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
    parameter logic [DW-1:0]    SP_RST     = 'hFF,
    parameter logic [AW-1:0]    VEC_NMI    = 'hFFFA,
    parameter logic [AW-1:0]    VEC_IRQ    = 'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pull_req,
    input  logic          brk_req,
    input  logic          irq_req,
    input  logic          nmi_req,
    input  logic          rti_req,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic [AW-1:0] call_target,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] psw_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] psw_out,
    output logic [DW-1:0] pull_data,
    output logic          busy,
    output logic          done
);

    ssq_state_e          state_q;
    logic [AW-1:0]       pc_q;
    logic [AW-1:0]       tgt_q;
    logic [DW-1:0]       psw_q;
    logic [DW-1:0]       data_q;
    logic                brk_q;
    logic                vnmi_q;
    logic                call_q;
    logic                done_q;
    logic [RQ_COUNT-1:0] req_vec;
    logic [RQ_COUNT-1:0] grant;
    logic                req_any;
    logic [DW-1:0]       sp;
    logic [DW-1:0]       sp_up;
    logic                sp_dec;
    logic                sp_inc;

    // Gather requests in priority slots; maskable request gated by I.
    always_comb begin
        req_vec           = '0;
        req_vec[RQ_NMI]   = nmi_req;
        req_vec[RQ_IRQ]   = irq_req & ~psw_in[I_BIT];
        req_vec[RQ_BRK]   = brk_req;
        req_vec[RQ_RTI]   = rti_req;
        req_vec[RQ_CALL]  = call_req;
        req_vec[RQ_RET]   = ret_req;
        req_vec[RQ_PUSH]  = push_req;
        req_vec[RQ_PULL]  = pull_req;
    end

    ssq_arbiter #(
        .N (RQ_COUNT)
    ) u_arb (
        .req   (req_vec),
        .grant (grant),
        .any   (req_any)
    );

    // Pointer moves on every stack access of the current state.
    assign sp_dec = is_stack_write(state_q);
    assign sp_inc = is_stack_read(state_q);

    ssq_stack_ptr #(
        .SP_W   (DW),
        .SP_RST (SP_RST)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp),
        .sp_up (sp_up)
    );

    ssq_bus_mux #(
        .AW         (AW),
        .DW         (DW),
        .B_BIT      (B_BIT),
        .STACK_PAGE (STACK_PAGE),
        .VEC_NMI    (VEC_NMI),
        .VEC_IRQ    (VEC_IRQ)
    ) u_bus (
        .state    (state_q),
        .sp       (sp),
        .sp_up    (sp_up),
        .vec_nmi  (vnmi_q),
        .brk_flag (brk_q),
        .pc       (pc_q),
        .psw      (psw_q),
        .data     (data_q),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .we       (mem_we),
        .re       (mem_re)
    );

    // Sequencer: request acceptance, state stepping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            tgt_q   <= '0;
            psw_q   <= '0;
            data_q  <= '0;
            brk_q   <= 1'b0;
            vnmi_q  <= 1'b0;
            call_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_any) begin
                        pc_q   <= pc_in;
                        psw_q  <= psw_in;
                        tgt_q  <= call_target;
                        brk_q  <= grant[RQ_BRK];
                        vnmi_q <= grant[RQ_NMI];
                        call_q <= grant[RQ_CALL];
                    end
                    if (grant[RQ_NMI] || grant[RQ_IRQ] || grant[RQ_BRK] ||
                        grant[RQ_CALL]) begin
                        state_q <= ST_WR_PCH;
                    end else if (grant[RQ_RTI]) begin
                        state_q <= ST_RD_PSW;
                    end else if (grant[RQ_RET]) begin
                        state_q <= ST_RD_PCL;
                    end else if (grant[RQ_PUSH]) begin
                        data_q  <= push_data;
                        state_q <= ST_WR_BYTE;
                    end else if (grant[RQ_PULL]) begin
                        state_q <= ST_RD_BYTE;
                    end
                end
                ST_WR_PCH: state_q <= ST_WR_PCL;
                ST_WR_PCL: begin
                    if (call_q) begin
                        pc_q    <= tgt_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_WR_PSW;
                    end
                end
                ST_WR_PSW: begin
                    psw_q[I_BIT] <= 1'b1;
                    state_q      <= ST_RD_VLO;
                end
                ST_RD_VLO: begin
                    pc_q[DW-1:0] <= mem_rdata;
                    state_q      <= ST_RD_VHI;
                end
                ST_RD_VHI: begin
                    pc_q[AW-1:DW] <= mem_rdata;
                    done_q        <= 1'b1;
                    state_q       <= ST_IDLE;
                end
                ST_RD_PSW: begin
                    psw_q   <= mem_rdata;
                    state_q <= ST_RD_PCL;
                end
                ST_RD_PCL: begin
                    pc_q[DW-1:0] <= mem_rdata;
                    state_q      <= ST_RD_PCH;
                end
                ST_RD_PCH: begin
                    pc_q[AW-1:DW] <= mem_rdata;
                    done_q        <= 1'b1;
                    state_q       <= ST_IDLE;
                end
                ST_WR_BYTE: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_RD_BYTE: begin
                    data_q  <= mem_rdata;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Results and handshake outputs.
    assign pc_out    = pc_q;
    assign psw_out   = psw_q;
    assign pull_data = data_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;

endmodule

// File: rtl/ssq_stack_seq_chk.sv
// Module: protocol checker for the stack sequencer, bound to the top.
// Observes ports only; assumes synchronous active-low reset.
module ssq_stack_seq_chk #(
    parameter int               AW         = 16,
    parameter int               DW         = 8,
    parameter int               I_BIT      = 2,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pull_req,
    input logic          brk_req,
    input logic          irq_req,
    input logic          nmi_req,
    input logic          rti_req,
    input logic          call_req,
    input logic          ret_req,
    input logic [DW-1:0] psw_in,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic          busy,
    input logic          done
);

    logic only_masked_irq;

    // A maskable request that is blocked and has no other request beside it.
    assign only_masked_irq = irq_req && psw_in[I_BIT] && !nmi_req &&
                             !brk_req && !rti_req && !call_req &&
                             !ret_req && !push_req && !pull_req;

    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE)); // R1

    AST_WRITES_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - DW'(1))); // R6

    AST_PULLS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re) && mem_addr[AW-1:DW] == STACK_PAGE &&
         $past(mem_addr[AW-1:DW]) == STACK_PAGE) |->
        (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) + DW'(1))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re)); // R12

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && only_masked_irq) |=> !busy); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R3

endmodule

bind ssq_stack_seq ssq_stack_seq_chk #(
    .AW         (AW),
    .DW         (DW),
    .I_BIT      (I_BIT),
    .STACK_PAGE (STACK_PAGE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pull_req (pull_req),
    .brk_req  (brk_req),
    .irq_req  (irq_req),
    .nmi_req  (nmi_req),
    .rti_req  (rti_req),
    .call_req (call_req),
    .ret_req  (ret_req),
    .psw_in   (psw_in),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_ssq_stack_seq.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed corner tests.
module tb_ssq_stack_seq;

    localparam int OP_PUSH = 0;
    localparam int OP_PULL = 1;
    localparam int OP_BRK  = 2;
    localparam int OP_IRQ  = 3;
    localparam int OP_NMI  = 4;
    localparam int OP_RTI  = 5;
    localparam int OP_CALL = 6;
    localparam int OP_RET  = 7;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] pc;
        logic [7:0]  psw;
        logic [7:0]  dat;
        logic [15:0] tgt;
        logic [15:0] epc;
        logic [7:0]  epsw;
        logic [7:0]  edat;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 16'h1234, 8'h20, 8'h5A, 16'h0000, 16'h1234, 8'h20, 8'h00}, // R3
        '{3'd0, 16'h1234, 8'h20, 8'hC3, 16'h0000, 16'h1234, 8'h20, 8'h00}, // R3
        '{3'd1, 16'h1234, 8'h20, 8'h00, 16'h0000, 16'h1234, 8'h20, 8'hC3}, // R4
        '{3'd1, 16'h1234, 8'h20, 8'h00, 16'h0000, 16'h1234, 8'h20, 8'h5A}, // R4
        '{3'd2, 16'h4567, 8'h20, 8'h00, 16'h0000, 16'hA022, 8'h24, 8'h00}, // R6
        '{3'd5, 16'h0000, 8'h24, 8'h00, 16'h0000, 16'h4567, 8'h30, 8'h00}, // R9
        '{3'd3, 16'h1357, 8'h21, 8'h00, 16'h0000, 16'hA022, 8'h25, 8'h00}, // R7
        '{3'd5, 16'h0000, 8'h25, 8'h00, 16'h0000, 16'h1357, 8'h21, 8'h00}, // R9
        '{3'd4, 16'h2468, 8'h24, 8'h00, 16'h0000, 16'h9011, 8'h24, 8'h00}, // R8
        '{3'd5, 16'h0000, 8'h24, 8'h00, 16'h0000, 16'h2468, 8'h24, 8'h00}, // R9
        '{3'd6, 16'h8001, 8'h20, 8'h00, 16'hC000, 16'hC000, 8'h20, 8'h00}, // R10
        '{3'd7, 16'h0000, 8'h20, 8'h00, 16'h0000, 16'h8001, 8'h20, 8'h00}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, pull_req = 1'b0, brk_req = 1'b0;
    logic        irq_req = 1'b0, nmi_req = 1'b0, rti_req = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0;
    logic [7:0]  push_data = '0;
    logic [15:0] call_target = '0, pc_in = '0;
    logic [7:0]  psw_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, psw_out, pull_data;
    logic        mem_we, mem_re, busy, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0]  stk [256];
    logic [7:0]  e_sp;
    logic        acc_we [16];
    logic        acc_re [16];
    logic [15:0] acc_addr [16];
    logic [7:0]  acc_wd [16];
    int          acc_n;
    logic        exp_we [16];
    logic [15:0] exp_addr [16];
    logic [7:0]  exp_wd [16];
    int          exp_n;

    always #2.5 clk = ~clk;

    ssq_stack_seq dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pull_req(pull_req), .brk_req(brk_req), .irq_req(irq_req),
        .nmi_req(nmi_req), .rti_req(rti_req), .call_req(call_req),
        .ret_req(ret_req), .call_target(call_target), .pc_in(pc_in),
        .psw_in(psw_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .pc_out(pc_out), .psw_out(psw_out), .pull_data(pull_data),
        .busy(busy), .done(done)
    );

    // Memory model: stack page storage plus two fixed vectors.
    always @(posedge clk) begin
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    end

    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                       (mem_addr == 16'hFFFA) ? 8'h11 :
                       (mem_addr == 16'hFFFB) ? 8'h90 :
                       (mem_addr == 16'hFFFE) ? 8'h22 :
                       (mem_addr == 16'hFFFF) ? 8'hA0 : 8'hEE;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic add_exp(input logic we, input logic [15:0] a, input logic [7:0] d);
        exp_we[exp_n]   = we;
        exp_addr[exp_n] = a;
        exp_wd[exp_n]   = d;
        exp_n++;
    endtask

    // Expected access trace from the requirements, advancing the model pointer.
    task automatic build_exp(input int op, input logic [15:0] pc, input logic [7:0] psw,
                             input logic [7:0] dat);
        logic [15:0] vb;
        exp_n = 0;
        case (op)
            OP_PUSH: begin add_exp(1, {8'h01, e_sp}, dat); e_sp--; end
            OP_PULL: begin e_sp++; add_exp(0, {8'h01, e_sp}, 8'h00); end
            OP_BRK, OP_IRQ, OP_NMI: begin
                add_exp(1, {8'h01, e_sp}, pc[15:8]); e_sp--;
                add_exp(1, {8'h01, e_sp}, pc[7:0]);  e_sp--;
                add_exp(1, {8'h01, e_sp}, (op == OP_BRK) ? (psw | 8'h10) : (psw & 8'hEF));
                e_sp--;
                vb = (op == OP_NMI) ? 16'hFFFA : 16'hFFFE;
                add_exp(0, vb, 8'h00);
                add_exp(0, vb + 16'd1, 8'h00);
            end
            OP_RTI: for (int k = 0; k < 3; k++) begin e_sp++; add_exp(0, {8'h01, e_sp}, 8'h00); end
            OP_CALL: begin
                add_exp(1, {8'h01, e_sp}, pc[15:8]); e_sp--;
                add_exp(1, {8'h01, e_sp}, pc[7:0]);  e_sp--;
            end
            default: for (int k = 0; k < 2; k++) begin e_sp++; add_exp(0, {8'h01, e_sp}, 8'h00); end
        endcase
    endtask

    // Apply one request, record the access trace, compare results.
    task automatic run_op(input int op, input logic [15:0] pc, input logic [7:0] psw,
                          input logic [7:0] dat, input logic [15:0] tgt,
                          input logic [15:0] epc, input logic [7:0] epsw,
                          input logic [7:0] edat, input bit with_irq,
                          input bit poke_mid, input string tag);
        logic ok;
        build_exp(op, pc, psw, dat);
        @(negedge clk);
        pc_in = pc; psw_in = psw; push_data = dat; call_target = tgt;
        push_req = (op == OP_PUSH); pull_req = (op == OP_PULL);
        brk_req  = (op == OP_BRK);  irq_req  = (op == OP_IRQ) || with_irq;
        nmi_req  = (op == OP_NMI);  rti_req  = (op == OP_RTI);
        call_req = (op == OP_CALL); ret_req  = (op == OP_RET);
        @(negedge clk);
        {push_req, pull_req, brk_req, irq_req, nmi_req, rti_req, call_req, ret_req} = '0;
        acc_n = 0;
        while (busy && acc_n < 16) begin
            acc_we[acc_n] = mem_we; acc_re[acc_n] = mem_re;
            acc_addr[acc_n] = mem_addr; acc_wd[acc_n] = mem_wdata;
            acc_n++;
            @(negedge clk);
            push_req = poke_mid && (acc_n == 1);
        end
        push_req = 1'b0;
        chk(acc_n == exp_n, {tag, " access count"}, acc_n, exp_n);
        ok = (acc_n == exp_n);
        for (int k = 0; k < 16; k++) begin
            if (ok && k < exp_n) begin
                if (acc_we[k] != exp_we[k] || acc_re[k] == exp_we[k] ||
                    acc_addr[k] != exp_addr[k] || (exp_we[k] && acc_wd[k] != exp_wd[k])) begin
                    ok = 1'b0;
                    chk(1'b0, {tag, " trace"}, {acc_addr[k], acc_wd[k], 7'd0, acc_we[k]},
                        {exp_addr[k], exp_wd[k], 7'd0, exp_we[k]});
                end
            end
        end
        if (ok) chk(1'b1, tag, 0, 0);
        chk(done == 1'b1, "R12 done after last access", done, 1);
        chk(pc_out == epc, {tag, " pc_out"}, pc_out, epc);
        chk(psw_out == epsw, {tag, " psw_out"}, psw_out, epsw);
        if (op == OP_PULL) chk(pull_data == edat, {tag, " pull_data"}, pull_data, edat);
        @(negedge clk);
        chk(done == 1'b0, "R12 done single cycle", done, 0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) stk[k] = 8'h00;
        e_sp = 8'hFF;
        repeat (3) @(negedge clk);
        // R2: idle outputs during and right after reset.
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R2 reset idle",
            {busy, done, mem_we, mem_re}, 0);

        // Vector table: R1 R3 R4 R6 R7 R8 R9 R10 R11.
        for (int i = 0; i < NVEC; i++) begin
            run_op(int'(VECS[i].op), VECS[i].pc, VECS[i].psw, VECS[i].dat,
                   VECS[i].tgt, VECS[i].epc, VECS[i].epsw, VECS[i].edat, 1'b0, 1'b0,
                   $sformatf("vec%0d", i));
            if (i == 0) chk(acc_addr[0] == 16'h01FF, "R2 first push at 01FF", acc_addr[0], 16'h01FF);
            if (i == 4) chk(acc_addr[2][15:8] == 8'h01, "R1 status on stack page",
                            acc_addr[2], 16'h01FD);
        end

        // R7: masked hardware request leaves the block idle.
        @(negedge clk);
        psw_in = 8'h04; irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 4; k++) begin
                seen = seen | busy | done | mem_we;
                @(negedge clk);
            end
            chk(!seen, "R7 masked irq ignored", seen, 0);
        end
        run_op(OP_PUSH, 16'h0000, 8'h04, 8'h77, 16'h0, 16'h0000, 8'h04, 8'h00, 0, 0, "R7 ptr kept");

        // R8: non-maskable beats a simultaneous hardware request.
        run_op(OP_NMI, 16'h7777, 8'h00, 8'h00, 16'h0, 16'h9011, 8'h04, 8'h00, 1, 0, "R8 nmi priority");
        run_op(OP_RTI, 16'h0000, 8'h04, 8'h00, 16'h0, 16'h7777, 8'h00, 8'h00, 0, 0, "R9 rti after nmi");

        // R12: a push arriving mid-break is dropped.
        run_op(OP_BRK, 16'h0ABC, 8'h00, 8'h99, 16'h0, 16'hA022, 8'h04, 8'h00, 0, 1, "R12 busy drop");
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 3; k++) begin
                seen = seen | busy;
                @(negedge clk);
            end
            chk(!seen, "R12 no late start", seen, 0);
        end
        run_op(OP_RTI, 16'h0000, 8'h04, 8'h00, 16'h0, 16'h0ABC, 8'h10, 8'h00, 0, 0, "R6 rti after brk");

        // R5: wrap in both directions after a fresh reset.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_sp = 8'hFF;
        run_op(OP_PULL, 16'h0000, 8'h00, 8'h00, 16'h0, 16'h0000, 8'h00, stk[0], 0, 0, "R5 pull wrap");
        chk(acc_addr[0] == 16'h0100, "R5 pull wraps to 0100", acc_addr[0], 16'h0100);
        run_op(OP_PUSH, 16'h0000, 8'h00, 8'hAB, 16'h0, 16'h0000, 8'h00, 8'h00, 0, 0, "R5 push at 00");
        chk(acc_addr[0] == 16'h0100, "R5 push writes 0100", acc_addr[0], 16'h0100);
        run_op(OP_PUSH, 16'h0000, 8'h00, 8'hCD, 16'h0, 16'h0000, 8'h00, 8'h00, 0, 0, "R5 push wrap");
        chk(acc_addr[0] == 16'h01FF, "R5 push wraps to 01FF", acc_addr[0], 16'h01FF);
        run_op(OP_PULL, 16'h0000, 8'h00, 8'h00, 16'h0, 16'h0000, 8'h00, 8'hCD, 0, 0, "R4 pull back");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule